// File: doc/BRIEF.md
# USB Control Endpoint Sequencer

This block runs the three-stage control transfer on endpoint 0 of a USB device. The packet-level controller below it does the token handling, handshakes and FIFO storage. This sequencer receives each endpoint-0 interrupt as a single event pulse, which carries three flags: a packet is waiting, a stall went out, or the host abandoned the setup. The same event means different things depending on the stage of the transfer. For each event the sequencer answers with at most one group of single-cycle command strobes back to the controller. It also tracks how many data-stage bytes are left.

Standard requests are decoded by a separate request handler. The sequencer talks to it through a single valid/ready channel. The operation code on that channel says what the handler must do: judge a freshly arrived setup packet, fill the transmit FIFO with the next packet of a read response, drain one received packet of a write, or finish any work that has to wait until the status stage is done. At the handshake the handler returns a pass/fail result and, for a read, the length of its response. A bus-reset input stops any transfer in progress.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `bus_reset` is high, `req_valid` and every `cmd_*` strobe are low. After a bus reset, events carrying no waiting packet raise no request.
- R2: An event with `evt_stalled` set gives only one `cmd_clr_stalled` pulse. All its other flags are ignored, and the transfer stage does not change.
- R3: With no transfer running, an event with `evt_rx_ready` is a setup packet. Bytes 6–7 (`setup_data[63:48]`, little-endian) are the length. Bit 7 of byte 0 (`setup_data[7]`) is the direction. A length of zero selects the no-data path, direction 1 selects a read, and anything else selects a write. No-data and read setups raise op 0 (judge setup) with the packet on `req_setup`.
- R4: No-data path: if the handler succeeds, one strobe group gives `cmd_clr_rx_ready` and `cmd_data_end`. If it fails, the sequencer gives `cmd_send_stall` alone and returns to no transfer.
- R5: Read path: if the handler fails, the sequencer gives `cmd_send_stall` alone. If it succeeds, it gives `cmd_clr_rx_ready` and then sends the smaller of the length and `resp_len` bytes. Each packet is raised as op 1 with `req_len` = min(64, bytes left) and followed by `cmd_tx_ready`. The packet that brings the count to zero sets `req_last` and adds `cmd_data_end`. If nothing is to be sent, one zero-length last packet is sent.
- R6: During a read data stage, a plain event (no flags) confirms that the previous packet went out and starts the next one.
- R7: Write path: the setup event itself gives `cmd_clr_rx_ready`, with no handler request, and the length is loaded.
- R8: In a write data stage, each received packet raises op 2 with `req_len` = `rx_count`. `req_last` is set when the count is below 64 or covers the bytes still expected. A packet that is not last gets `cmd_clr_rx_ready`. A last packet that succeeds gets `cmd_clr_rx_ready` with `cmd_data_end`; one that fails gets `cmd_send_stall` and the transfer ends.
- R9: After the final data-end, the next plain event is the status stage. It raises op 3 (post-status), and after that handshake no transfer is running.
- R10: Except in the no-data status stage, an event with `evt_setup_end` gives `cmd_clr_setup_end` and ends the transfer. If the same event also has `evt_rx_ready`, it is handled at once as a new setup packet.
- R11: In the status stage of a no-data transfer, `evt_setup_end` gives `cmd_clr_setup_end` but counts as status completion (op 3), not as an abort.
- R12: A raised request keeps `req_valid`, `req_op` and `req_len` steady until `req_ready`, and each request is handed over exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | USB bus reset seen; abandons the transfer and clears the count |
| evt_valid | input | 1 | Endpoint-0 event pulse |
| evt_rx_ready | input | 1 | Event flag: a received packet is waiting |
| evt_stalled | input | 1 | Event flag: a stall handshake was sent |
| evt_setup_end | input | 1 | Event flag: host abandoned the setup |
| rx_count | input | 7 | Byte count of the waiting received packet |
| setup_data | input | 64 | The eight setup bytes, byte 0 in bits 7:0 |
| req_valid | output | 1 | Request to the handler is pending |
| req_op | output | 2 | 0 judge setup, 1 load transmit packet, 2 take received packet, 3 post-status |
| req_len | output | 7 | Packet length for ops 1 and 2 |
| req_last | output | 1 | Packet is the final one of the data stage |
| req_setup | output | 64 | Setup packet captured for op 0 |
| req_ready | input | 1 | Handler accepts the request |
| req_ok | input | 1 | Handler result, sampled at the handshake |
| resp_len | input | 16 | Read response length, sampled at the op-0 handshake |
| cmd_clr_rx_ready | output | 1 | Strobe: release the received packet |
| cmd_tx_ready | output | 1 | Strobe: transmit packet is loaded |
| cmd_data_end | output | 1 | Strobe: data stage complete |
| cmd_send_stall | output | 1 | Strobe: answer with a stall |
| cmd_clr_setup_end | output | 1 | Strobe: acknowledge setup abandonment |
| cmd_clr_stalled | output | 1 | Strobe: acknowledge the sent stall |

## Verification
Reads are swept across request lengths on both sides of the 64-byte packet size, paired with response lengths from zero to beyond the request. This separates the short-response case, the request-limited case, the exact-multiple case (no trailing empty packet) and the empty-response case, and it uses several handler latencies. Writes are swept across the same lengths, both with full packets and with an early short packet. This shows that either termination rule alone closes the stage. Directed runs cover failing requests, stall and abort flags arriving mid-transfer (an abort with and without a pending setup), an abort flag during no-data status, and a bus reset during a write.

// File: rtl/ep0_seq_pkg.sv
// Shared types of the endpoint-0 control sequencer.
// Assumes: handler operation codes are fixed by the port contract.
package ep0_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_TX_LOAD,
        ST_TX_WAIT,
        ST_STATUS,
        ST_ZL_STATUS,
        ST_RX,
        ST_RX_PROC,
        ST_POST
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_SETUP       = 2'd0,
        OP_TX_LOAD     = 2'd1,
        OP_RX_DATA     = 2'd2,
        OP_POST_STATUS = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        KIND_NODATA,
        KIND_READ,
        KIND_WRITE
    } xfer_kind_e;

    typedef struct packed {
        logic clr_rx;
        logic tx_rdy;
        logic data_end;
        logic stall;
        logic clr_setend;
        logic clr_stalled;
    } cmd_t;

endpackage

// File: rtl/ep0_setup_decode.sv
// Classifies a setup packet into no-data, read or write transfer.
// Assumes: length field is little-endian in bytes 6..7, direction in bit 7.
module ep0_setup_decode
    import ep0_seq_pkg::*;
#(
    parameter int unsigned SETUP_W = 64,
    parameter int unsigned LEN_W   = 16
) (
    input  logic [SETUP_W-1:0] setup,
    output xfer_kind_e         kind,
    output logic [LEN_W-1:0]   wlen
);
    localparam int unsigned LEN_LSB = 48;
    localparam int unsigned DIR_BIT = 7;

    // Pick the length field and derive the transfer kind.
    always_comb begin
        wlen = setup[LEN_LSB +: LEN_W];
        if (wlen == '0)
            kind = KIND_NODATA;
        else if (setup[DIR_BIT])
            kind = KIND_READ;
        else
            kind = KIND_WRITE;
    end
endmodule

// File: rtl/ep0_byte_counter.sv
// Remaining data-stage byte counter with load and saturating decrement.
// Assumes: clear wins over load, load wins over decrement.
module ep0_byte_counter #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    input  logic [LEN_W-1:0] dec_val,
    output logic [LEN_W-1:0] remaining
);
    // Hold, load or count down the bytes still expected.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            remaining <= '0;
        else if (load)
            remaining <= load_val;
        else if (dec)
            remaining <= (dec_val > remaining) ? '0 : remaining - dec_val;
    end
endmodule

// File: rtl/ep0_pkt_sizer.sv
// Computes the next transmit packet size and the last-packet tests.
// Assumes: MAX_PKT fits in CNT_W bits and LEN_W >= CNT_W.
module ep0_pkt_sizer #(
    parameter int unsigned MAX_PKT = 64,
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned CNT_W   = 7
) (
    input  logic [LEN_W-1:0] remaining,
    input  logic [CNT_W-1:0] rx_count,
    output logic [CNT_W-1:0] tx_len,
    output logic             tx_last,
    output logic             rx_last
);
    localparam logic [LEN_W-1:0] MPS_L = LEN_W'(MAX_PKT);
    localparam logic [CNT_W-1:0] MPS_C = CNT_W'(MAX_PKT);

    // Transmit: take a full packet unless fewer bytes remain.
    always_comb begin
        tx_last = (remaining <= MPS_L);
        tx_len  = tx_last ? remaining[CNT_W-1:0] : MPS_C;
    end

    // Receive: short packet or expected total reached closes the stage.
    always_comb begin
        rx_last = (rx_count < MPS_C) || (LEN_W'(rx_count) >= remaining);
    end
endmodule

// File: rtl/ep0_ctrl_seq.sv
// Endpoint-0 control transfer sequencer.
// Turns controller event pulses into command strobes, walks the setup, data
// and status stages, and drives handler requests over valid/ready.
// Assumes: events arriving while a handler request is pending are dropped;
// one event pulse per endpoint-0 interrupt.
module ep0_ctrl_seq
    import ep0_seq_pkg::*;
#(
    parameter int unsigned MAX_PKT     = 64,
    parameter int unsigned LEN_W       = 16,
    parameter int unsigned SETUP_BYTES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_reset,
    input  logic                         evt_valid,
    input  logic                         evt_rx_ready,
    input  logic                         evt_stalled,
    input  logic                         evt_setup_end,
    input  logic [$clog2(MAX_PKT):0]     rx_count,
    input  logic [SETUP_BYTES*8-1:0]     setup_data,
    output logic                         req_valid,
    output logic [1:0]                   req_op,
    output logic [$clog2(MAX_PKT):0]     req_len,
    output logic                         req_last,
    output logic [SETUP_BYTES*8-1:0]     req_setup,
    input  logic                         req_ready,
    input  logic                         req_ok,
    input  logic [LEN_W-1:0]             resp_len,
    output logic                         cmd_clr_rx_ready,
    output logic                         cmd_tx_ready,
    output logic                         cmd_data_end,
    output logic                         cmd_send_stall,
    output logic                         cmd_clr_setup_end,
    output logic                         cmd_clr_stalled
);
    localparam int unsigned CNT_W   = $clog2(MAX_PKT) + 1;
    localparam int unsigned SETUP_W = SETUP_BYTES * 8;

    seq_state_e          state_q, state_n;
    xfer_kind_e          kind_q, kind_n, dec_kind;
    logic [LEN_W-1:0]    wlen_q, wlen_n, dec_wlen;
    logic [SETUP_W-1:0]  setup_q, setup_n;
    logic [CNT_W-1:0]    rxlen_q, rxlen_n;
    logic                rxlast_q, rxlast_n;
    cmd_t                cmd_q, cmd_n;

    logic                cnt_load, cnt_dec;
    logic [LEN_W-1:0]    cnt_val, dec_val, remaining, rd_total;
    logic [CNT_W-1:0]    tx_len;
    logic                tx_last, rx_last;
    logic                take_setup, hs;

    ep0_setup_decode #(.SETUP_W(SETUP_W), .LEN_W(LEN_W)) u_decode (
        .setup (setup_data),
        .kind  (dec_kind),
        .wlen  (dec_wlen)
    );

    ep0_byte_counter #(.LEN_W(LEN_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (bus_reset),
        .load      (cnt_load),
        .load_val  (cnt_val),
        .dec       (cnt_dec),
        .dec_val   (dec_val),
        .remaining (remaining)
    );

    ep0_pkt_sizer #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_sizer (
        .remaining (remaining),
        .rx_count  (rx_count),
        .tx_len    (tx_len),
        .tx_last   (tx_last),
        .rx_last   (rx_last)
    );

    // Handler request outputs follow the registered stage.
    always_comb begin
        req_valid = 1'b0;
        req_op    = OP_SETUP;
        req_len   = '0;
        req_last  = 1'b0;
        unique case (state_q)
            ST_SETUP:   req_valid = 1'b1;
            ST_TX_LOAD: begin
                req_valid = 1'b1;
                req_op    = OP_TX_LOAD;
                req_len   = tx_len;
                req_last  = tx_last;
            end
            ST_RX_PROC: begin
                req_valid = 1'b1;
                req_op    = OP_RX_DATA;
                req_len   = rxlen_q;
                req_last  = rxlast_q;
            end
            ST_POST: begin
                req_valid = 1'b1;
                req_op    = OP_POST_STATUS;
            end
            default: ;
        endcase
    end

    assign req_setup = setup_q;
    assign hs        = req_valid && req_ready;
    assign rd_total  = (resp_len < wlen_q) ? resp_len : wlen_q;

    // Next stage, strobe group and counter control for this cycle.
    always_comb begin
        state_n    = state_q;
        kind_n     = kind_q;
        wlen_n     = wlen_q;
        setup_n    = setup_q;
        rxlen_n    = rxlen_q;
        rxlast_n   = rxlast_q;
        cmd_n      = '0;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        cnt_dec    = 1'b0;
        dec_val    = '0;
        take_setup = 1'b0;
        unique case (state_q)
            ST_SETUP: if (hs) begin
                if (!req_ok) begin
                    cmd_n.stall = 1'b1;
                    state_n     = ST_IDLE;
                end else if (kind_q == KIND_NODATA) begin
                    cmd_n.clr_rx   = 1'b1;
                    cmd_n.data_end = 1'b1;
                    state_n        = ST_ZL_STATUS;
                end else begin
                    cmd_n.clr_rx = 1'b1;
                    cnt_load     = 1'b1;
                    cnt_val      = rd_total;
                    state_n      = ST_TX_LOAD;
                end
            end
            ST_TX_LOAD: if (hs) begin
                cmd_n.tx_rdy   = 1'b1;
                cmd_n.data_end = tx_last;
                cnt_dec        = 1'b1;
                dec_val        = LEN_W'(tx_len);
                state_n        = tx_last ? ST_STATUS : ST_TX_WAIT;
            end
            ST_RX_PROC: if (hs) begin
                cnt_dec = 1'b1;
                dec_val = LEN_W'(rxlen_q);
                if (!rxlast_q) begin
                    cmd_n.clr_rx = 1'b1;
                    state_n      = ST_RX;
                end else if (req_ok) begin
                    cmd_n.clr_rx   = 1'b1;
                    cmd_n.data_end = 1'b1;
                    state_n        = ST_STATUS;
                end else begin
                    cmd_n.stall = 1'b1;
                    state_n     = ST_IDLE;
                end
            end
            ST_POST: if (hs) state_n = ST_IDLE;
            default: if (evt_valid) begin
                if (evt_stalled) begin
                    cmd_n.clr_stalled = 1'b1;
                end else if (evt_setup_end && state_q != ST_ZL_STATUS) begin
                    cmd_n.clr_setend = 1'b1;
                    state_n          = ST_IDLE;
                    take_setup       = evt_rx_ready;
                end else begin
                    unique case (state_q)
                        ST_IDLE:    take_setup = evt_rx_ready;
                        ST_TX_WAIT: state_n = ST_TX_LOAD;
                        ST_STATUS:  state_n = ST_POST;
                        ST_ZL_STATUS: begin
                            cmd_n.clr_setend = evt_setup_end;
                            state_n          = ST_POST;
                        end
                        ST_RX: if (evt_rx_ready) begin
                            rxlen_n  = rx_count;
                            rxlast_n = rx_last;
                            state_n  = ST_RX_PROC;
                        end
                        default: ;
                    endcase
                end
            end
        endcase
        if (take_setup) begin
            kind_n  = dec_kind;
            wlen_n  = dec_wlen;
            setup_n = setup_data;
            if (dec_kind == KIND_WRITE) begin
                cmd_n.clr_rx = 1'b1;
                cnt_load     = 1'b1;
                cnt_val      = dec_wlen;
                state_n      = ST_RX;
            end else begin
                state_n = ST_SETUP;
            end
        end
    end

    // Register stage, captured setup data and the strobe group.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            state_q  <= ST_IDLE;
            kind_q   <= KIND_NODATA;
            wlen_q   <= '0;
            setup_q  <= '0;
            rxlen_q  <= '0;
            rxlast_q <= 1'b0;
            cmd_q    <= '0;
        end else begin
            state_q  <= state_n;
            kind_q   <= kind_n;
            wlen_q   <= wlen_n;
            setup_q  <= setup_n;
            rxlen_q  <= rxlen_n;
            rxlast_q <= rxlast_n;
            cmd_q    <= cmd_n;
        end
    end

    assign cmd_clr_rx_ready  = cmd_q.clr_rx;
    assign cmd_tx_ready      = cmd_q.tx_rdy;
    assign cmd_data_end      = cmd_q.data_end;
    assign cmd_send_stall    = cmd_q.stall;
    assign cmd_clr_setup_end = cmd_q.clr_setend;
    assign cmd_clr_stalled   = cmd_q.clr_stalled;
endmodule

// File: rtl/ep0_seq_checker.sv
// Protocol checks on the sequencer ports, bound to every instance.
// Assumes: only port-level signals are observed.
module ep0_seq_checker #(
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_reset,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [CNT_W-1:0] req_len,
    input logic             req_ready,
    input logic             cmd_clr_rx_ready,
    input logic             cmd_tx_ready,
    input logic             cmd_data_end,
    input logic             cmd_send_stall,
    input logic             cmd_clr_setup_end,
    input logic             cmd_clr_stalled
);
    // R1: bus reset quiets requests and strobes on the next cycle.
    p_bus_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !req_valid && !cmd_clr_rx_ready && !cmd_tx_ready &&
                      !cmd_data_end && !cmd_send_stall && !cmd_clr_setup_end &&
                      !cmd_clr_stalled);

    // R2: a stall acknowledgement travels alone.
    p_stall_ack_alone_r2: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        cmd_clr_stalled |-> !cmd_clr_rx_ready && !cmd_tx_ready && !cmd_data_end &&
                            !cmd_send_stall && !cmd_clr_setup_end);

    // R4: send-stall never rides with data-stage strobes.
    p_stall_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        cmd_send_stall |-> !cmd_clr_rx_ready && !cmd_tx_ready && !cmd_data_end);

    // R5: data-end pairs with exactly one of release or transmit.
    p_data_end_paired_r5: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        cmd_data_end |-> (cmd_clr_rx_ready != cmd_tx_ready));

    // R6: each loaded packet waits for a completion event before the next.
    p_tx_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        cmd_tx_ready |=> !cmd_tx_ready);

    // R12: a pending request stays put until accepted.
    p_request_hold_r12: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_len));
endmodule

bind ep0_ctrl_seq ep0_seq_checker #(.CNT_W(CNT_W)) u_ep0_seq_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .bus_reset         (bus_reset),
    .req_valid         (req_valid),
    .req_op            (req_op),
    .req_len           (req_len),
    .req_ready         (req_ready),
    .cmd_clr_rx_ready  (cmd_clr_rx_ready),
    .cmd_tx_ready      (cmd_tx_ready),
    .cmd_data_end      (cmd_data_end),
    .cmd_send_stall    (cmd_send_stall),
    .cmd_clr_setup_end (cmd_clr_setup_end),
    .cmd_clr_stalled   (cmd_clr_stalled)
);

// File: tb/test_ep0_ctrl_seq.sv
// Self-checking bench: swept read and write transfers plus directed corners.
module test_ep0_ctrl_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        evt_valid = 1'b0, evt_rx_ready = 1'b0, evt_stalled = 1'b0, evt_setup_end = 1'b0;
    logic [6:0]  rx_count = '0;
    logic [63:0] setup_data = '0;
    logic        req_valid, req_last;
    logic [1:0]  req_op;
    logic [6:0]  req_len;
    logic [63:0] req_setup;
    logic        req_ready = 1'b0, req_ok = 1'b1;
    logic [15:0] resp_len = '0;
    logic        cmd_clr_rx_ready, cmd_tx_ready, cmd_data_end;
    logic        cmd_send_stall, cmd_clr_setup_end, cmd_clr_stalled;

    ep0_ctrl_seq i_ep0_ctrl_seq (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .evt_valid(evt_valid), .evt_rx_ready(evt_rx_ready),
        .evt_stalled(evt_stalled), .evt_setup_end(evt_setup_end),
        .rx_count(rx_count), .setup_data(setup_data),
        .req_valid(req_valid), .req_op(req_op), .req_len(req_len),
        .req_last(req_last), .req_setup(req_setup),
        .req_ready(req_ready), .req_ok(req_ok), .resp_len(resp_len),
        .cmd_clr_rx_ready(cmd_clr_rx_ready), .cmd_tx_ready(cmd_tx_ready),
        .cmd_data_end(cmd_data_end), .cmd_send_stall(cmd_send_stall),
        .cmd_clr_setup_end(cmd_clr_setup_end), .cmd_clr_stalled(cmd_clr_stalled)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    int hdl_delay = 0, wait_cnt = 0, n_ops = 0;
    int op_log[64], len_log[64], last_log[64], wl_log[64];
    int c_clr_rx = 0, c_tx = 0, c_de = 0, c_stall = 0, c_setend = 0, c_clrst = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Handler model: accepts each request after hdl_delay cycles and logs it.
    always @(negedge clk) begin
        req_ready = 1'b0;
        if (rst_n && req_valid) begin
            if (wait_cnt >= hdl_delay) begin
                req_ready = 1'b1;
                if (n_ops < 64) begin
                    op_log[n_ops]   = int'(req_op);
                    len_log[n_ops]  = int'(req_len);
                    last_log[n_ops] = int'(req_last);
                    wl_log[n_ops]   = int'(req_setup[63:48]);
                end
                n_ops++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    // Strobe tallies.
    always @(negedge clk) begin
        if (cmd_clr_rx_ready)  c_clr_rx++;
        if (cmd_tx_ready)      c_tx++;
        if (cmd_data_end)      c_de++;
        if (cmd_send_stall)    c_stall++;
        if (cmd_clr_setup_end) c_setend++;
        if (cmd_clr_stalled)   c_clrst++;
    end

    task automatic clear_log();
        n_ops = 0; c_clr_rx = 0; c_tx = 0; c_de = 0;
        c_stall = 0; c_setend = 0; c_clrst = 0;
    endtask

    function automatic logic [63:0] mk_setup(input logic [7:0] rtype, input int w);
        logic [15:0] w16 = w[15:0];
        return {w16, 40'h0, rtype};
    endfunction

    task automatic send_evt(input bit rx, input bit st, input bit se, input int cnt);
        @(negedge clk);
        evt_valid = 1'b1; evt_rx_ready = rx; evt_stalled = st; evt_setup_end = se;
        rx_count = cnt[6:0];
        @(negedge clk);
        evt_valid = 1'b0; evt_rx_ready = 1'b0; evt_stalled = 1'b0; evt_setup_end = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic run_read(input int w, input int r, input int dly);
        int total, n, ln;
        clear_log();
        hdl_delay = dly; req_ok = 1'b1; resp_len = r[15:0];
        setup_data = mk_setup(8'h80, w);
        send_evt(1, 0, 0, 0);
        total = (w < r) ? w : r;
        n = (total == 0) ? 1 : (total + 63) / 64;
        for (int k = 1; k < n; k++) send_evt(0, 0, 0, 0);
        send_evt(0, 0, 0, 0);
        check(n_ops == n + 2, "R5", n_ops, n + 2);
        check(op_log[0] == 0 && wl_log[0] == w, "R3", op_log[0], 0);
        for (int k = 0; k < n; k++) begin
            ln = (k < n - 1) ? 64 : total - 64 * (n - 1);
            check(op_log[k+1] == 1 && len_log[k+1] == ln && last_log[k+1] == int'(k == n - 1),
                  "R5", len_log[k+1], ln);
        end
        check(c_tx == n, "R6", c_tx, n);
        check(c_clr_rx == 1 && c_de == 1 && c_stall == 0, "R5", c_de, 1);
        check(op_log[n+1] == 3 && !req_valid, "R9", op_log[n+1], 3);
    endtask

    task automatic run_write(input int w, input int s, input int dly);
        int rem, c, n;
        bit last;
        clear_log();
        hdl_delay = dly; req_ok = 1'b1;
        setup_data = mk_setup(8'h00, w);
        send_evt(1, 0, 0, 0);
        check(c_clr_rx == 1 && n_ops == 0, "R7", c_clr_rx, 1);
        rem = w; n = 0; last = 1'b0;
        while (!last) begin
            c = (s > 0 && n == 0) ? s : ((rem >= 64) ? 64 : rem);
            last = (c < 64) || (c >= rem);
            send_evt(1, 0, 0, c);
            check(op_log[n] == 2 && len_log[n] == c && last_log[n] == int'(last),
                  "R8", len_log[n], c);
            rem = (c >= rem) ? 0 : rem - c;
            n++;
        end
        check(c_clr_rx == n + 1 && c_de == 1 && c_stall == 0, "R8", c_clr_rx, n + 1);
        send_evt(0, 0, 0, 0);
        check(n_ops == n + 1 && op_log[n] == 3 && !req_valid, "R9", n_ops, n + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!req_valid && !cmd_clr_rx_ready && !cmd_tx_ready && !cmd_send_stall &&
              !cmd_data_end && !cmd_clr_setup_end && !cmd_clr_stalled, "R1", int'(req_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!req_valid && c_tx == 0 && c_clr_rx == 0, "R1", int'(req_valid), 0);

        // Read sweep across request and response lengths.
        begin
            int wl[6] = '{1, 63, 64, 65, 128, 200};
            int rl[5] = '{0, 1, 64, 100, 200};
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 5; j++) run_read(wl[i], rl[j], (i + j) % 3);
            // Write sweep, full packets and early short packet.
            for (int i = 0; i < 6; i++) begin
                run_write(wl[i], 0, i % 3);
                run_write(wl[i], 5, (i + 1) % 3);
            end
        end

        // R4: no-data success, then plain status event.
        clear_log(); hdl_delay = 1; req_ok = 1'b1;
        setup_data = mk_setup(8'h00, 0);
        send_evt(1, 0, 0, 0);
        check(n_ops == 1 && op_log[0] == 0 && c_clr_rx == 1 && c_de == 1, "R4", c_de, 1);
        send_evt(0, 0, 0, 0);
        check(n_ops == 2 && op_log[1] == 3, "R9", op_log[1], 3);

        // R11: abort flag during no-data status completes the status stage.
        clear_log(); setup_data = mk_setup(8'h80, 0);
        send_evt(1, 0, 0, 0);
        send_evt(0, 0, 1, 0);
        check(c_setend == 1 && n_ops == 2 && op_log[1] == 3 && !req_valid, "R11", n_ops, 2);

        // R4: no-data failure stalls and returns to no transfer.
        clear_log(); req_ok = 1'b0; setup_data = mk_setup(8'h00, 0);
        send_evt(1, 0, 0, 0);
        check(c_stall == 1 && c_clr_rx == 0 && c_de == 0, "R4", c_stall, 1);
        send_evt(0, 0, 0, 0);
        check(n_ops == 1, "R4", n_ops, 1);

        // R5: read failure stalls.
        clear_log(); setup_data = mk_setup(8'h80, 40);
        send_evt(1, 0, 0, 0);
        send_evt(0, 0, 0, 0);
        check(c_stall == 1 && c_tx == 0 && n_ops == 1, "R5", c_tx, 0);

        // R8: failing last write packet stalls and ends the transfer.
        clear_log(); req_ok = 1'b1; setup_data = mk_setup(8'h00, 100);
        send_evt(1, 0, 0, 0);
        send_evt(1, 0, 0, 64);
        req_ok = 1'b0;
        send_evt(1, 0, 0, 36);
        check(c_stall == 1 && c_de == 0 && c_clr_rx == 2, "R8", c_stall, 1);
        send_evt(0, 0, 0, 0);
        check(n_ops == 2, "R8", n_ops, 2);
        req_ok = 1'b1;

        // R2: stalled event mid-read is acknowledged and otherwise ignored.
        clear_log(); hdl_delay = 0; resp_len = 16'd200; setup_data = mk_setup(8'h80, 200);
        send_evt(1, 0, 0, 0);
        send_evt(1, 1, 1, 0);
        check(c_clrst == 1 && c_setend == 0 && n_ops == 2 && c_clr_rx == 1, "R2", c_clrst, 1);
        send_evt(0, 0, 0, 0);
        check(n_ops == 3 && op_log[2] == 1 && len_log[2] == 64, "R2", n_ops, 3);

        // R10: abort with a waiting setup re-enters setup at once.
        clear_log(); setup_data = mk_setup(8'h00, 0);
        send_evt(1, 0, 1, 0);
        check(c_setend == 1 && n_ops == 1 && op_log[0] == 0 && wl_log[0] == 0 &&
              c_clr_rx == 1 && c_de == 1, "R10", n_ops, 1);
        send_evt(0, 0, 0, 0);

        // R10: abort without a waiting packet just ends the transfer.
        clear_log(); setup_data = mk_setup(8'h80, 150);
        send_evt(1, 0, 0, 0);
        send_evt(0, 0, 1, 0);
        check(c_setend == 1 && n_ops == 2, "R10", c_setend, 1);
        send_evt(0, 0, 0, 0);
        check(n_ops == 2 && c_tx == 1, "R10", n_ops, 2);

        // R12: slow handler, each request handed over once.
        run_read(130, 130, 4);
        check(n_ops == 5, "R12", n_ops, 5);

        // R1: bus reset mid-write.
        clear_log(); hdl_delay = 0; setup_data = mk_setup(8'h00, 200);
        send_evt(1, 0, 0, 0);
        send_evt(1, 0, 0, 64);
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        check(!req_valid && !cmd_clr_rx_ready, "R1", int'(req_valid), 0);
        send_evt(0, 0, 0, 0);
        check(n_ops == 1 && c_clr_rx == 2, "R1", n_ops, 1);
        run_write(70, 0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule